// File: doc/BRIEF.md
# Cumulative and Consecutive Ones Monitor

This block watches a single serial bit `a` sampled on every rising clock edge and raises two sticky flags. Flag `x` reports that the bit has been seen high on at least three cycles in total, whether those cycles are adjacent or spread out. Flag `y` reports that the bit has been seen high on two cycles in a row. Each flag is held until the next synchronous reset, so a consumer can sample them at any later time.

Both flags are Moore outputs that come from registers. Each flag rises in the cycle after the sample that qualifies it. The parameter `VARIANT` selects one of two internal structures with the same port behaviour. With `VARIANT` = 0 the block is a single merged state machine of nine minimized states. In that machine, every condition where both flags are set collapses into one absorbing state. With `VARIANT` = 1 the block is a two-bit saturating tally beside a two-bit run register that locks once it holds two ones.

Top module: `ones_monitor`

## Requirements
- R1: While `rst` is high at a rising edge, both `x` and `y` read 0 after that edge.
- R2: `x` becomes 1 in the cycle after the third edge since reset at which `a` was sampled 1, whether or not those samples were adjacent.
- R3: While fewer than three high samples of `a` have been taken since reset, `x` stays 0.
- R4: `y` becomes 1 in the cycle after the second of two consecutive edges at which `a` was sampled 1.
- R5: Isolated high samples of `a`, each separated from the next by at least one low sample, never set `y`.
- R6: Once `x` or `y` is 1, it stays 1 at every later edge until `rst` is sampled high.
- R7: Once both flags are 1, no input sequence on `a` changes either flag before the next reset.
- R8: `VARIANT` 0 and `VARIANT` 1 produce identical `x` and `y` sequences for any stimulus.
- R9: A reset in the middle of a sequence discards all high samples seen before it, and counting of both criteria restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 1 | Serial bit sampled every cycle |
| x | output | 1 | Sticky flag: three or more high samples in total |
| y | output | 1 | Sticky flag: two adjacent high samples |

## Verification
A wrong internal state shows at the ports within one to three cycles. A lost or extra tally step moves the rise of `x` by one cycle. A run register or merged state that forgets the previous bit makes `y` rise after isolated ones, or not rise after a pair. A terminal state that is not absorbing lets a flag drop, and that appears on the very next edge. Because the two variants are compared cycle by cycle against one scoreboard, any divergence between them is caught in the cycle it first appears.

// File: rtl/ones_mon_pkg.sv
package ones_mon_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // tally of high samples, saturating at the total threshold
  localparam int TALLY_W   = 2;
  localparam int TALLY_SAT = (1 << TALLY_W) - 1;
  // length of the adjacent-ones window
  localparam int RUN_W     = 2;

  // minimized merged machine: tally / last bit / run flag
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,  // tally 0
    ST_ONE_HI   = 4'd1,  // tally 1, last bit 1
    ST_ONE_LO   = 4'd2,  // tally 1, last bit 0
    ST_TWO_HI   = 4'd3,  // tally 2, last bit 1, no run yet
    ST_TWO_LO   = 4'd4,  // tally 2, last bit 0, no run yet
    ST_TWO_RUN  = 4'd5,  // tally 2, run seen
    ST_THREE_HI = 4'd6,  // tally 3, last bit 1, no run yet
    ST_THREE_LO = 4'd7,  // tally 3, last bit 0, no run yet
    ST_BOTH     = 4'd8   // absorbing: both flags set
  } mon_state_e;

  function automatic logic total_flag(input mon_state_e s);
    return (s == ST_THREE_HI) || (s == ST_THREE_LO) || (s == ST_BOTH);
  endfunction

  function automatic logic run_flag(input mon_state_e s);
    return (s == ST_TWO_RUN) || (s == ST_BOTH);
  endfunction
endpackage

// File: rtl/merged_fsm.sv
module merged_fsm
  import ones_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic x,
  output logic y
);
  timeunit 1ns;
  timeprecision 100ps;

  mon_state_e state_q, state_d;
  logic       x_q, y_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     state_d = a ? ST_ONE_HI   : ST_IDLE;
      ST_ONE_HI:   state_d = a ? ST_TWO_RUN  : ST_ONE_LO;
      ST_ONE_LO:   state_d = a ? ST_TWO_HI   : ST_ONE_LO;
      ST_TWO_HI:   state_d = a ? ST_BOTH     : ST_TWO_LO;
      ST_TWO_LO:   state_d = a ? ST_THREE_HI : ST_TWO_LO;
      ST_TWO_RUN:  state_d = a ? ST_BOTH     : ST_TWO_RUN;
      ST_THREE_HI: state_d = a ? ST_BOTH     : ST_THREE_LO;
      ST_THREE_LO: state_d = a ? ST_THREE_HI : ST_THREE_LO;
      ST_BOTH:     state_d = ST_BOTH;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      x_q     <= 1'b0;
      y_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      x_q     <= total_flag(state_d);
      y_q     <= run_flag(state_d);
    end
  end

  assign x = x_q;
  assign y = y_q;
endmodule

// File: rtl/tally_track.sv
module tally_track
  import ones_mon_pkg::*;
#(
  parameter int W   = TALLY_W,
  parameter int SAT = TALLY_SAT
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic x
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [W-1:0] SAT_V = W'(SAT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         x_q;

  always_comb begin
    cnt_d = cnt_q;
    if (a && (cnt_q != SAT_V)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      x_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      x_q   <= (cnt_d == SAT_V);
    end
  end

  assign x = x_q;
endmodule

// File: rtl/run_track.sv
module run_track
  import ones_mon_pkg::*;
#(
  parameter int W = RUN_W
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic y
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [W-1:0] sh_q, sh_d;
  logic         y_q;

  // shift until the window is all ones, then lock
  always_comb begin
    if (&sh_q) sh_d = sh_q;
    else       sh_d = {sh_q[W-2:0], a};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      y_q  <= 1'b0;
    end else begin
      sh_q <= sh_d;
      y_q  <= &sh_d;
    end
  end

  assign y = y_q;
endmodule

// File: rtl/ones_monitor.sv
module ones_monitor #(
  parameter int VARIANT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic x,
  output logic y
);
  timeunit 1ns;
  timeprecision 100ps;

  generate
    if (VARIANT == 0) begin : g_merged
      merged_fsm u_fsm (.clk(clk), .rst(rst), .a(a), .x(x), .y(y));
    end else begin : g_split
      tally_track u_tally (.clk(clk), .rst(rst), .a(a), .x(x));
      run_track   u_run   (.clk(clk), .rst(rst), .a(a), .y(y));
    end
  endgenerate
endmodule

// File: rtl/ones_monitor_chk.sv
module ones_monitor_chk (
  input logic clk,
  input logic rst,
  input logic a,
  input logic x,
  input logic y
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)                     seen_q <= 2'd0;
    else if (a && seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (!x && !y));
  // R2
  x_follows_tally_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 2'd3) |-> x);
  // R3
  x_quiet_early_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd3) |-> !x);
  // R4
  y_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(y) |-> ($past(a) && $past(a, 2)));
  // R6
  x_sticky_chk: assert property (@(posedge clk) disable iff (rst) x |=> x);
  // R6
  y_sticky_chk: assert property (@(posedge clk) disable iff (rst) y |=> y);
  // R7
  both_absorb_chk: assert property (@(posedge clk) disable iff (rst)
    (x && y) |=> (x && y));
endmodule

bind ones_monitor ones_monitor_chk chk_i (
  .clk(clk), .rst(rst), .a(a), .x(x), .y(y)
);

// File: tb/ones_monitor_test.sv
module ones_monitor_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a   = 1'b0;
  logic x0, y0, x1, y1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit    q_x[$];
  bit    q_y[$];
  string q_tag[$];

  // model state
  int m_cnt  = 0;
  bit m_prev = 1'b0;
  bit m_x    = 1'b0;
  bit m_y    = 1'b0;

  always #2.5 clk = ~clk;

  ones_monitor #(.VARIANT(0)) uut     (.clk(clk), .rst(rst), .a(a), .x(x0), .y(y0));
  ones_monitor #(.VARIANT(1)) uut_alt (.clk(clk), .rst(rst), .a(a), .x(x1), .y(y1));

  // driver: apply one cycle and push the expected outputs after the edge
  task automatic step(input bit av, input bit rv, input string tag);
    @(negedge clk);
    a   = av;
    rst = rv;
    if (rv) begin
      m_cnt = 0; m_prev = 1'b0; m_x = 1'b0; m_y = 1'b0;
    end else begin
      if (av && m_cnt < 3) m_cnt++;
      if (av && m_prev) m_y = 1'b1;
      m_prev = av;
      if (m_cnt >= 3) m_x = 1'b1;
    end
    q_x.push_back(m_x);
    q_y.push_back(m_y);
    q_tag.push_back(tag);
  endtask

  task automatic seq(input bit [31:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b0, tag);
  endtask

  task automatic cmp(input string tag, input string who, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, who, act, exp);
    end
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (q_x.size() > 0) begin
      bit    ex, ey;
      string tg;
      ex = q_x.pop_front();
      ey = q_y.pop_front();
      tg = q_tag.pop_front();
      cmp(tg, "uut.x", x0, ex);
      cmp(tg, "uut.y", y0, ey);
      cmp({tg, "/R8"}, "uut_alt.x", x1, ex);
      cmp({tg, "/R8"}, "uut_alt.y", y1, ey);
    end
  end

  initial begin
    step(1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
    // mixed pattern: pair then total of three
    seq(32'b0110111, 7, "R2_R4");
    step(1'b0, 1'b1, "R1");
    // isolated ones, then a late pair
    seq(32'b1010110, 7, "R5_R2");
    step(1'b0, 1'b1, "R1");
    // only two highs, far apart
    seq(32'b100100000, 9, "R3_R5");
    seq(32'b1, 1, "R2");
    seq(32'b0000000000, 10, "R6");
    // pair now sets y, then arbitrary input
    seq(32'b11, 2, "R4");
    for (int i = 0; i < 24; i++) step(i[0] ^ i[2], 1'b0, "R7");
    // reset in the middle discards earlier highs
    step(1'b0, 1'b1, "R1");
    seq(32'b11, 2, "R4");
    step(1'b1, 1'b1, "R9");
    seq(32'b101, 3, "R9");
    seq(32'b1, 1, "R9_R2");
    seq(32'b0000, 4, "R6");
    seq(32'b1, 1, "R6");
    seq(32'b00, 2, "R6");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule